// File: doc/BRIEF.md
# Clock-Gated Handshake Pipeline Stage

This block is one register stage placed between two units of an on-chip packet fabric. Each side uses the same three-wire handshake. The sender drives a data word and a valid bit. The receiver drives a ready bit. A word moves across an edge only in a cycle where valid and ready are both high. Because both sides of the stage use the same handshake, any number of stages can be chained with no glue logic.

The stage holds up to `DEPTH` words (two by default) in a small ring of slots. This lets the ready bit toward the sender come straight from a flop, so it has no combinational path from the downstream ready. The stage can still take and deliver one word per cycle.

A slot is written only in a cycle where a word enters the stage. The enable for that write is built from the stage's own handshake wires and nothing else, and it is brought out as a port. On any cycle with no incoming transfer the storage does not toggle, whatever the rest of the fabric is doing. The control flops are also enabled only on cycles with an incoming or outgoing transfer.

Top module: `gated_skid_stage`

## Requirements
- R1: While reset is active and in the first cycle after it, `outValid` is 0 and `inReady` is 1. The data slots have no reset value.
- R2: A word is taken in only in a cycle where `inValid` and `inReady` are both 1. It leaves only in a cycle where `outValid` and `outReady` are both 1. Every word taken in leaves exactly once, in arrival order.
- R3: `inReady` is 0 only while the stage holds `DEPTH` words. It returns to 1 only in the cycle after a word has left.
- R4: If `outValid` is 1 and `outReady` is 0, then in the next cycle `outValid` is still 1 and `outData` is unchanged.
- R5: `gateEn` is 1 in exactly those cycles where `inValid` and `inReady` are both 1.
- R6: In a cycle where `gateEn` is 0 and no word leaves, `outData` does not change in the next cycle, whatever `inData` and `inValid` do.
- R7: With `inValid` and `outReady` held at 1, the stage accepts and delivers one word every cycle, and `inReady` stays at 1.
- R8: While `outReady` is 0, the stage accepts exactly `DEPTH` words and then drops `inReady`. Words offered while `inReady` is 0 are not stored and never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream word present |
| inReady | output | 1 | Stage can take a word (registered) |
| inData | input | DATA_W | Upstream word |
| outValid | output | 1 | Stage presents a word |
| outReady | input | 1 | Downstream takes the word |
| outData | output | DATA_W | Presented word |
| gateEn | output | 1 | Local storage clock enable |

## Verification
On every cycle, the assertions check four things:
- the storage enable equals the incoming handshake;
- the output holds valid and data while it is stalled;
- the output data stays still on cycles with no write and no drain;
- the sender-side ready is low only while the output is valid, and rises only after a drain.

Only the bench's scenarios can show the rest:
- that words come out in order with none lost or duplicated;
- that full throughput holds under continuous flow;
- that the stage fills to exactly its depth under back-pressure;
- that words offered while full are truly discarded.

// File: rtl/gss_pkg.sv
package gss_pkg;

  // Widest slot index carried in the strobe bundle; DEPTH must fit in it.
  localparam int IDX_W = 4;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic             wrEn;   // a word enters this cycle (local clock enable)
    logic [IDX_W-1:0] wrIdx;  // slot to be written
    logic [IDX_W-1:0] rdIdx;  // slot presented at the output
  } ctrlStrobes_t;

endpackage

// File: rtl/gss_ctrl.sv
module gss_ctrl
  import gss_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNext;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             inReadyQ;
  logic             outValidQ;
  logic             accept;
  logic             drain;
  logic             ctrlEn;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign accept = inValid & inReadyQ;
  assign drain  = outValidQ & outReady;
  assign ctrlEn = accept | drain;

  always_comb begin
    countNext = count;
    if (accept && !drain)      countNext = count + CNT_W'(1);
    else if (drain && !accept) countNext = count - CNT_W'(1);
  end

  // Control state moves only on a handshake at either edge of the stage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      inReadyQ  <= 1'b1;
      outValidQ <= 1'b0;
    end else if (ctrlEn) begin
      count     <= countNext;
      inReadyQ  <= (countNext != FULL_CNT);
      outValidQ <= (countNext != '0);
      if (accept) wrPtr <= nextPtr(wrPtr);
      if (drain)  rdPtr <= nextPtr(rdPtr);
    end
  end

  assign inReady  = inReadyQ;
  assign outValid = outValidQ;

  always_comb begin
    strobes       = '0;
    strobes.wrEn  = accept;
    strobes.wrIdx = IDX_W'(wrPtr);
    strobes.rdIdx = IDX_W'(rdPtr);
  end

endmodule

// File: rtl/gss_datapath.sv
module gss_datapath
  import gss_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [DEPTH-1:0]  slotEn;

  // One enable per slot, derived only from the local write strobe.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slotEn[i] = strobes.wrEn && (strobes.wrIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (slotEn[i]) slotQ[i] <= inData;
    end
  end

  always_comb begin
    outData = slotQ[0];
    for (int k = 1; k < DEPTH; k++) begin
      if (strobes.rdIdx == IDX_W'(k)) outData = slotQ[k];
    end
  end

endmodule

// File: rtl/gated_skid_stage.sv
module gated_skid_stage
  import gss_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              gateEn
);

  if (DEPTH < 2 || DEPTH > (1 << IDX_W)) begin : g_bad_depth
    initial $error("gated_skid_stage: DEPTH out of range");
  end

  ctrlStrobes_t strobes;

  gss_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  gss_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .inData  (inData),
    .outData (outData)
  );

  assign gateEn = strobes.wrEn;

endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              gateEn
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && inReady));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R5
  gate_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateEn == (inValid && inReady));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gateEn && !(outValid && outReady)) |=> $stable(outData));

  // R3
  full_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> outValid);

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && !(outValid && outReady)) |=> !inReady);

endmodule

bind gated_skid_stage gss_checker #(.DATA_W(DATA_W)) u_gss_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .gateEn   (gateEn)
);

// File: tb/gated_skid_stage_bench.sv
module gated_skid_stage_bench;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [DATA_W-1:0] outData;
  logic              gateEn;

  int                checks = 0;
  int                fails = 0;
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] nextWord = 32'h1000_0000;
  logic [15:0]       lfsr = 16'hACE1;
  logic              prevStall = 1'b0;
  logic [DATA_W-1:0] prevData = '0;
  logic              prevQuiet = 1'b0;
  bit                monOn = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  gated_skid_stage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_gated_skid_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .gateEn(gateEn)
  );

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Driver: moves inputs just after the edge.
  task automatic drive(input bit v, input bit r);
    @(posedge clk); #1;
    inValid  = v;
    outReady = r;
    inData   = v ? nextWord : {lfsr, lfsr};
  endtask

  // Monitor / scoreboard, sampling at the falling edge.
  always @(negedge clk) begin
    if (monOn) begin
      // R5: local enable equals the incoming handshake
      check(gateEn == (inValid && inReady), "R5", {31'b0, gateEn}, {31'b0, inValid && inReady});
      // R4: a stalled output holds
      if (prevStall) begin
        check(outValid, "R4 valid", {31'b0, outValid}, 32'd1);
        check(outData == prevData, "R4 data", outData, prevData);
      end
      // R6: no write and no drain leaves outData still
      if (prevQuiet) check(outData == prevData, "R6", outData, prevData);
      // R3: not ready only while valid
      if (!inReady) check(outValid, "R3", {31'b0, outValid}, 32'd1);
      // R2: in-order delivery
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R2 extra word", outData, '0);
        else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          check(outData == e, "R2", outData, e);
        end
      end
      if (inValid && inReady) begin
        expQ.push_back(inData);
        nextWord = nextWord + 32'd1;
      end
      prevStall = outValid && !outReady;
      prevQuiet = !(inValid && inReady) && !(outValid && outReady);
      prevData  = outData;
      lfsr      = step(lfsr);
    end
  end

  initial begin
    int   fullCnt;
    logic [DATA_W-1:0] lastSeen;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!outValid, "R1 outValid", {31'b0, outValid}, 32'd0);
    check(inReady, "R1 inReady", {31'b0, inReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && inReady, "R1 after reset", {30'b0, outValid, inReady}, 32'd1);
    monOn = 1'b1;

    // R7: continuous flow
    drive(1'b1, 1'b1);
    for (int i = 0; i < 60; i++) begin
      drive(1'b1, 1'b1);
      @(negedge clk);
      check(inReady, "R7 ready", {31'b0, inReady}, 32'd1);
      if (i > 0) check(outValid, "R7 valid", {31'b0, outValid}, 32'd1);
    end

    // R2 / R4: mixed patterns
    for (int i = 0; i < 400; i++) drive(lfsr[0] | lfsr[3], lfsr[5]);
    for (int i = 0; i < 200; i++) drive(lfsr[1], lfsr[2] & lfsr[7]);
    drive(1'b0, 1'b1);
    repeat (4) drive(1'b0, 1'b1);

    // R8: fill under back-pressure, then offer extra words
    fullCnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      inValid = 1'b1; outReady = 1'b0; inData = nextWord;
      @(negedge clk);
      if (inReady) fullCnt++;
    end
    check(fullCnt == DEPTH, "R8 fill count", fullCnt, DEPTH);
    check(!inReady, "R8 ready low", {31'b0, inReady}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      inData = 32'hDEAD_0000 + i;
      @(negedge clk);
      check(!inReady, "R8 still full", {31'b0, inReady}, 32'd0);
    end
    // R6: idle with toggling data
    for (int i = 0; i < 20; i++) drive(1'b0, 1'b0);
    // drain; scoreboard flags any discarded word that escapes
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b1);
    check(expQ.size() == 0, "R8 drained", expQ.size(), 0);

    // R6: long idle after drain, output held
    drive(1'b0, 1'b0);
    @(negedge clk);
    lastSeen = outData;
    for (int i = 0; i < 30; i++) drive(1'b0, i[0]);
    @(negedge clk);
    check(outData == lastSeen, "R6 idle hold", outData, lastSeen);
    check(!outValid, "R2 empty", {31'b0, outValid}, 32'd0);

    monOn = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule